// File: doc/BRIEF.md
# Subaddressed Block Buffer with FIFO Staging

This block is the host-side store of a command/response serial terminal. It holds 2048 sixteen-bit words, split into 64 blocks of 32 words. A block is chosen by a direction flag and a five-bit subaddress. The host never addresses the store directly. It sets up a small control register, stages words in an inbound FIFO or collects them from an outbound FIFO, and then writes to a trigger location. After the trigger, a transfer engine moves one block between the chosen FIFO and the chosen RAM block.

When a move finishes, the engine raises a one-cycle completion pulse. An availability flag goes high as soon as the outbound FIFO holds a word, so the host may drain it while the copy is still running. A mode pin lets a byte-wide host reach every register through separate low-byte and high-byte accesses.

Top module: `sab_engine`

## Requirements
- R1: After a synchronous reset, `done` and `ofifo_avail` are 0, both FIFOs are empty, and the control register reads 0.
- R2: Control register (port 0x0) layout: bits [4:0] are the subaddress (bit 0 least significant), bit 5 is the direction flag, bit 6 is the copy direction (1 = FIFO to RAM, 0 = RAM to FIFO). Bits 15 and 14 are read-only and give busy and overflow. RAM word address = {direction flag, subaddress, offset[4:0]}, so each of the 64 blocks is distinct.
- R3: With bit 6 set, a trigger copies the n staged words (0 ≤ n ≤ 32) to offsets 0..n-1 of the block. Other offsets keep their contents. The inbound FIFO is empty afterwards, and `done` is high in the cycle after the (n+1)th clock edge following the trigger.
- R4: With bit 6 clear, a trigger copies all 32 words of the block, in offset order, into the outbound FIFO. The host reads them at port 0xF. `done` is high after the 33rd edge following the trigger.
- R5: A write of any value to port 0x8 is a trigger. The data value has no effect.
- R6: A write to port 0xB empties the inbound FIFO and clears the overflow flag. A write to port 0xD empties the outbound FIFO.
- R7: `ofifo_avail` is high whenever the outbound FIFO is non-empty. During a RAM-to-FIFO copy it rises after the 2nd edge following the trigger, before `done`.
- R8: `done` is a single-cycle pulse, issued once per transfer.
- R9: A trigger that arrives while busy (bit 15 = 1) is ignored. The running transfer keeps its block and length.
- R10: Writes to port 0xE beyond 32 staged words are discarded and set the overflow flag (bit 14). The flag stays set until port 0xB is written.
- R11: With `narrow` = 1, reads return one byte in bits [7:0]: the low byte when `hi_sel` = 0, the high byte when `hi_sel` = 1. A low-byte write to port 0xE holds the byte, and the next high-byte write pushes {high, low}. Only a low-byte write changes the control register, and only a high-byte read at port 0xF removes the word.
- R12: Reading port 0xF while the outbound FIFO is empty returns 0 and removes nothing. Reads of unused ports return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| narrow | input | 1 | 1 = byte-wide host access |
| hi_sel | input | 1 | In byte mode, selects the high byte |
| wr_en | input | 1 | Host write strobe, one cycle per access |
| rd_en | input | 1 | Host read strobe, one cycle per access |
| addr | input | 4 | Host port address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Registered host read data, held between reads |
| done | output | 1 | Transfer-complete pulse |
| ofifo_avail | output | 1 | Outbound FIFO holds at least one word |

## Verification
The assertions assume that the host never asserts `wr_en` and `rd_en` together. They also assume that, while a FIFO-to-RAM copy runs, the host does not load, clear or retarget the inbound FIFO, and that the outbound FIFO is emptied before each RAM-to-FIFO trigger so that it never overflows. The stimulus keeps to these rules: it issues one access per cycle, waits for the reference model's busy state to clear before touching the inbound FIFO, and writes port 0xD before every outbound copy. Reads and repeated triggers during a transfer are deliberately allowed.

// File: rtl/sab_pkg.sv
package sab_pkg;
  // Host port map; these values are decoded by the host software.
  localparam logic [3:0] A_OPREG = 4'h0;
  localparam logic [3:0] A_EXEC  = 4'h8;
  localparam logic [3:0] A_ICLR  = 4'hB;
  localparam logic [3:0] A_OCLR  = 4'hD;
  localparam logic [3:0] A_ILOAD = 4'hE;
  localparam logic [3:0] A_OREAD = 4'hF;
endpackage

// File: rtl/sab_in_fifo.sv
module sab_in_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         drain,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic [$clog2(DEPTH)-1:0]     rd_idx,
  output logic [DW-1:0]                rd_data,
  output logic [$clog2(DEPTH):0]       count,
  output logic                         ovf
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          ovf_q;

  always_ff @(posedge clk) begin
    if (push && cnt_q != FULL && !clr && !drain) mem[cnt_q[IW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (drain) begin
      cnt_q <= '0;
    end else if (push) begin
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      else               ovf_q <= 1'b1;
    end
  end

  assign rd_data = mem[rd_idx];
  assign count   = cnt_q;
  assign ovf     = ovf_q;

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr) |=> ovf_q);
  // R10
  in_full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && cnt_q == FULL && !clr && !drain) |=> (cnt_q == FULL && ovf_q));
endmodule

// File: rtl/sab_out_fifo.sv
module sab_out_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     push,
  input  logic [DW-1:0]            push_data,
  input  logic                     pop,
  output logic [DW-1:0]            head,
  output logic                     nonempty
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ne_q;
  logic          do_push, do_pop;

  assign do_push = push && cnt_q != FULL;
  assign do_pop  = pop && cnt_q != '0;

  always_comb begin
    cnt_d = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ne_q  <= 1'b0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_d;
      ne_q  <= (cnt_d != '0);
    end
  end

  assign head     = ne_q ? mem[rp_q] : '0;
  assign nonempty = ne_q;

  // R7
  avail_after_push_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !clr) |=> nonempty);
  // R6
  oclr_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !nonempty);
endmodule

// File: rtl/sab_msg_ram.sv
module sab_msg_ram #(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rd_q <= mem[raddr];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/sab_xfer_ctrl.sv
module sab_xfer_ctrl #(
  parameter int BLK_W     = 6,
  parameter int BLK_WORDS = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic                              dir_in,
  input  logic [BLK_W-1:0]                  blk_sel,
  input  logic [$clog2(BLK_WORDS):0]        in_count,
  output logic                              busy,
  output logic                              done,
  output logic                              ram_we,
  output logic                              ram_re,
  output logic [BLK_W+$clog2(BLK_WORDS)-1:0] ram_addr,
  output logic [$clog2(BLK_WORDS)-1:0]      in_idx,
  output logic                              in_drain,
  output logic                              ofifo_push
);
  localparam int OW = $clog2(BLK_WORDS);
  localparam int CW = OW + 1;
  localparam logic [CW-1:0] LAST = CW'(BLK_WORDS);

  logic             busy_q, dir_q, done_q;
  logic [BLK_W-1:0] blk_q;
  logic [CW-1:0]    len_q, cnt_q;
  logic             in_end, out_end;

  assign in_end  = busy_q && dir_q && cnt_q == len_q;
  assign out_end = busy_q && !dir_q && cnt_q == LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
      blk_q  <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= in_end || out_end;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          dir_q  <= dir_in;
          blk_q  <= blk_sel;
          len_q  <= in_count;
          cnt_q  <= '0;
        end
      end else if (in_end || out_end) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign ram_we     = busy_q && dir_q && !in_end;
  assign ram_re     = busy_q && !dir_q && cnt_q < LAST;
  assign ram_addr   = {blk_q, cnt_q[OW-1:0]};
  assign in_idx     = cnt_q[OW-1:0];
  assign in_drain   = in_end;
  assign ofifo_push = busy_q && !dir_q && cnt_q != '0;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start && !(in_end || out_end)) |=> ($stable(blk_q) && $stable(len_q) && busy_q));
  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $fell(busy_q));
endmodule

// File: rtl/sab_engine.sv
module sab_engine #(
  parameter int DW        = 16,
  parameter int SA_W      = 5,
  parameter int BLK_WORDS = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          narrow,
  input  logic          hi_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [3:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          ofifo_avail
);
  import sab_pkg::*;

  localparam int OW    = $clog2(BLK_WORDS);
  localparam int CW    = OW + 1;
  localparam int BLK_W = SA_W + 1;
  localparam int RAW   = BLK_W + OW;
  localparam int OPW   = SA_W + 2;
  localparam int HW    = DW / 2;
  localparam int PADW  = DW - OPW - 2;

  logic [OPW-1:0] op_q;
  logic [HW-1:0]  stage_q;
  logic [DW-1:0]  rdata_q, rd_val, rd_sel;

  logic            busy, ram_we, ram_re, in_drain, ofifo_push;
  logic [RAW-1:0]  ram_addr;
  logic [DW-1:0]   ram_rdata, in_rd_data, ohead;
  logic [OW-1:0]   in_idx;
  logic [CW-1:0]   in_count;
  logic            in_ovf;

  logic            exec, iclr, oclr, ipush, opop;
  logic [DW-1:0]   ipush_data;

  assign exec       = wr_en && addr == A_EXEC;
  assign iclr       = wr_en && addr == A_ICLR;
  assign oclr       = wr_en && addr == A_OCLR;
  assign ipush      = wr_en && addr == A_ILOAD && (!narrow || hi_sel);
  assign ipush_data = narrow ? {wdata[HW-1:0], stage_q} : wdata;
  assign opop       = rd_en && addr == A_OREAD && (!narrow || hi_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= '0;
      stage_q <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en && addr == A_OPREG && (!narrow || !hi_sel)) op_q <= wdata[OPW-1:0];
      if (wr_en && addr == A_ILOAD && narrow && !hi_sel)    stage_q <= wdata[HW-1:0];
      if (rd_en) rdata_q <= rd_sel;
    end
  end

  always_comb begin
    case (addr)
      A_OPREG: rd_val = {busy, in_ovf, {PADW{1'b0}}, op_q};
      A_OREAD: rd_val = ohead;
      default: rd_val = '0;
    endcase
    if (narrow) rd_sel = hi_sel ? {{HW{1'b0}}, rd_val[DW-1:HW]} : {{HW{1'b0}}, rd_val[HW-1:0]};
    else        rd_sel = rd_val;
  end

  sab_in_fifo #(.DW(DW), .DEPTH(BLK_WORDS)) u_in_fifo (
    .clk(clk), .rst(rst), .clr(iclr), .drain(in_drain),
    .push(ipush), .push_data(ipush_data),
    .rd_idx(in_idx), .rd_data(in_rd_data),
    .count(in_count), .ovf(in_ovf)
  );

  sab_out_fifo #(.DW(DW), .DEPTH(BLK_WORDS)) u_out_fifo (
    .clk(clk), .rst(rst), .clr(oclr),
    .push(ofifo_push), .push_data(ram_rdata),
    .pop(opop), .head(ohead), .nonempty(ofifo_avail)
  );

  sab_msg_ram #(.DW(DW), .AW(RAW)) u_msg_ram (
    .clk(clk), .we(ram_we), .waddr(ram_addr), .wdata(in_rd_data),
    .re(ram_re), .raddr(ram_addr), .rdata(ram_rdata)
  );

  sab_xfer_ctrl #(.BLK_W(BLK_W), .BLK_WORDS(BLK_WORDS)) u_xfer_ctrl (
    .clk(clk), .rst(rst), .start(exec), .dir_in(op_q[SA_W+1]),
    .blk_sel(op_q[SA_W:0]), .in_count(in_count),
    .busy(busy), .done(done), .ram_we(ram_we), .ram_re(ram_re),
    .ram_addr(ram_addr), .in_idx(in_idx), .in_drain(in_drain),
    .ofifo_push(ofifo_push)
  );

  assign rdata = rdata_q;

  // R4
  push_excl_write_chk: assert property (@(posedge clk) disable iff (rst)
    ofifo_push |-> !ram_we);
  // R3
  ram_write_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (busy && CW'(in_idx) < in_count));
  // R12
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_OREAD && !narrow && !ofifo_avail) |=> rdata == '0);
endmodule

// File: tb/test_sab_engine.sv
module test_sab_engine;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1, narrow = 1'b0, hi_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        done, ofifo_avail;

  sab_engine i_sab_engine (
    .clk(clk), .rst(rst), .narrow(narrow), .hi_sel(hi_sel), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .done(done), .ofifo_avail(ofifo_avail)
  );

  int    checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  // behavioural reference
  logic [15:0] mem [0:2047];
  logic [15:0] inq[$], outq[$];
  logic [6:0]  m_op;
  logic        m_ovf, m_busy, m_dir, m_done;
  logic [5:0]  m_blk;
  int          m_len, m_cnt;
  logic [15:0] m_rdq, m_rdata;
  logic [7:0]  m_stage;

  always @(posedge clk) begin : model
    logic        bo;
    logic [15:0] v;
    if (rst) begin
      inq.delete(); outq.delete();
      m_op = 0; m_ovf = 0; m_busy = 0; m_dir = 0; m_done = 0; m_blk = 0;
      m_len = 0; m_cnt = 0; m_rdata = 0; m_stage = 0; m_rdq = 0;
    end else begin
      bo = m_busy;
      m_done = 0;
      if (rd_en) begin
        case (addr)
          4'h0:    v = {m_busy, m_ovf, 7'b0, m_op};
          4'hF:    v = (outq.size() != 0) ? outq[0] : 16'h0;
          default: v = 16'h0;
        endcase
        if (narrow) v = hi_sel ? {8'h0, v[15:8]} : {8'h0, v[7:0]};
        m_rdata = v;
        if (addr == 4'hF && (!narrow || hi_sel) && outq.size() != 0) void'(outq.pop_front());
      end
      if (bo) begin
        if (m_dir) begin
          if (m_cnt == m_len) begin m_busy = 0; m_done = 1; inq.delete(); end
          else begin mem[{m_blk, 5'(m_cnt)}] = inq[m_cnt]; m_cnt++; end
        end else begin
          if (m_cnt != 0 && outq.size() < 32) outq.push_back(m_rdq);
          if (m_cnt < 32) m_rdq = mem[{m_blk, 5'(m_cnt)}];
          if (m_cnt == 32) begin m_busy = 0; m_done = 1; end
          else m_cnt++;
        end
      end
      if (wr_en) begin
        case (addr)
          4'h0: if (!narrow || !hi_sel) m_op = wdata[6:0];
          4'h8: if (!bo) begin
                  m_busy = 1; m_dir = m_op[6]; m_blk = m_op[5:0];
                  m_len = inq.size(); m_cnt = 0;
                end
          4'hB: begin inq.delete(); m_ovf = 0; end
          4'hD: outq.delete();
          4'hE: if (narrow && !hi_sel) m_stage = wdata[7:0];
                else begin
                  v = narrow ? {wdata[7:0], m_stage} : wdata;
                  if (inq.size() < 32) inq.push_back(v); else m_ovf = 1;
                end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cycles++;
      check(done === m_done, "done(R8)", int'(done), int'(m_done));
      check(ofifo_avail === (outq.size() != 0), "avail(R7)", int'(ofifo_avail), int'(outq.size() != 0));
      check(rdata === m_rdata, "rdata", int'(rdata), int'(m_rdata));
    end
  end

  task automatic op(input logic w, input logic r, input logic [3:0] a,
                    input logic [15:0] d, input logic h);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; hi_sel = h;
  endtask
  task automatic wr(input logic [3:0] a, input logic [15:0] d); op(1, 0, a, d, 0); endtask
  task automatic rd(input logic [3:0] a); op(0, 1, a, 16'h0, 0); endtask
  task automatic idle(); op(0, 0, 4'h0, 16'h0, 0); endtask
  task automatic wait_idle();
    idle();
    for (int k = 0; k < 100 && m_busy; k++) idle();
  endtask
  task automatic fill(input logic [6:0] o, input int n, input logic [15:0] b);
    wr(4'h0, {9'h0, o}); wr(4'hB, 16'h0);
    for (int k = 0; k < n; k++) wr(4'hE, b + 16'(k));
    wr(4'h8, 16'h0); wait_idle();
  endtask
  task automatic dump(input logic [6:0] o);
    wr(4'h0, {9'h0, o}); wr(4'hD, 16'h0); wr(4'h8, 16'h5A5A); wait_idle();
    for (int k = 0; k < 32; k++) rd(4'hF);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R1"; rd(4'h0); rd(4'hF); idle();
    tag = "R2";
    fill(7'h65, 32, 16'h1000); fill(7'h45, 32, 16'h2000);
    fill(7'h7F, 32, 16'h3000); fill(7'h40, 32, 16'h4000);
    tag = "R4"; dump(7'h05); dump(7'h25);
    tag = "R3"; wr(4'h0, 16'h0065); wr(4'hB, 0);
    for (int k = 0; k < 3; k++) wr(4'hE, 16'hAAA0 + 16'(k));
    tag = "R5"; wr(4'h8, 16'hFFFF); wait_idle();
    tag = "R3"; dump(7'h25);
    tag = "R7"; wr(4'h0, 16'h003F); wr(4'hD, 0); wr(4'h8, 16'h1234);
    for (int k = 0; k < 40; k++) rd(4'hF);
    idle();
    tag = "R9"; wr(4'h0, 16'h0040); wr(4'hB, 0);
    for (int k = 0; k < 20; k++) wr(4'hE, 16'h5500 + 16'(k));
    wr(4'h8, 0); idle(); wr(4'h0, 16'h0001); wr(4'h8, 0); rd(4'h0); wr(4'h8, 0);
    wait_idle(); rd(4'h0); dump(7'h00);
    tag = "R10"; wr(4'h0, 16'h0041); wr(4'hB, 0);
    for (int k = 0; k < 34; k++) wr(4'hE, 16'h6600 + 16'(k));
    rd(4'h0); wr(4'h8, 0); wait_idle(); rd(4'h0);
    wr(4'hB, 0); rd(4'h0); dump(7'h01);
    tag = "R11"; idle(); narrow = 1'b1;
    op(1, 0, 4'h0, 16'h0045, 0); op(1, 0, 4'h0, 16'h00FF, 1);
    op(0, 1, 4'h0, 0, 0); op(0, 1, 4'h0, 0, 1);
    wr(4'hB, 0);
    for (int k = 0; k < 4; k++) begin
      op(1, 0, 4'hE, 16'h0010 + 16'(k), 0); op(1, 0, 4'hE, 16'h00C0 + 16'(k), 1);
    end
    wr(4'h8, 0); wait_idle();
    op(1, 0, 4'h0, 16'h0005, 0); wr(4'hD, 0); wr(4'h8, 0); wait_idle();
    for (int k = 0; k < 32; k++) begin op(0, 1, 4'hF, 0, 0); op(0, 1, 4'hF, 0, 1); end
    idle(); narrow = 1'b0;
    tag = "R6"; wr(4'hD, 0); wr(4'h8, 0); wait_idle();
    rd(4'hF); rd(4'hF); wr(4'hD, 0); rd(4'hF); idle();
    tag = "R12"; rd(4'hF); rd(4'h3); idle();
    tag = "R3"; wr(4'hB, 0); wr(4'h0, 16'h006A); wr(4'h8, 0); wait_idle(); rd(4'h0);
    tag = "R2"; dump(7'h3F); dump(7'h20);
    idle(); idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog expired exp=finished act=hung");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule